// File: doc/BRIEF.md
# Channel Correction and Quantizer

This block sits after a real-input FFT and before the output packetiser of a radio channelizer. Each complex frequency bin receives a fine-delay phase correction: the phase grows linearly with the channel index and also carries a constant fringe-stopping offset. The bin is then scaled by a complex bandpass gain that software loads for each channel. The result is rounded and saturated to signed 8-bit real and imaginary parts.

Spectra arrive time-major. For each spectrum the bins come in order, with both polarizations of a bin next to each other. The block gathers 256 spectra into a heap and writes the heap out channel-major, so that each channel's run of spectra leaves as one contiguous stream. A heap that holds any spectrum flagged unusable is dropped whole. Two heap-sized banks take turns, so one heap can be filled while the previous one drains.

Top module: `chan_correct_quant`

## Requirements
- R1: Each spectrum presents NCH+1 bins, indices 0..NCH, and each bin presents polarization 0 and then polarization 1. Bin NCH is the Nyquist bin and is discarded: neither its values nor its `in_bad` flag affect any output.
- R2: Channel k is rotated by θ = 2π·((P0 + k·D) mod 256)/256, where P0 is `cfg_phase0` and D is `cfg_phase_step`. The trig values are c = round(16384·cos θ) and s = round(16384·sin θ), and the block forms A = re·c − im·s and B = re·s + im·c.
- R3: The rotated value is multiplied by the channel's complex gain (gr, gi), a signed 16-bit pair written through `cfg_we`/`cfg_ch`: Vr = A·gr − B·gi and Vi = A·gi + B·gr. Unity gain is gr = 4096.
- R4: Each output part equals Vr/2^26 (or Vi/2^26) rounded to the nearest integer, with halves rounded away from zero.
- R5: Results saturate to the range −127..+127. The value −128 never appears on the outputs.
- R6: A heap leaves as NCH·256·2 consecutive `out_valid` beats in channel-major order (channel, then spectrum, then polarization). `out_last` is high on the final beat only.
- R7: A heap in which any non-Nyquist sample carries `in_bad` produces no output beats. Later heaps are not affected.
- R8: Gain writes and phase-port changes made while a heap is being received take effect from the first sample of the next heap. Every heap uses the values present at its first sample.
- R9: The first output beat of a heap appears in the cycle after the heap's last input sample is accepted. Heaps may be streamed back to back with no gap and without loss.
- R10: After reset `out_valid` is low, every channel gain is unity, and the phase registers are zero, so data passes through unchanged when |value| ≤ 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_re | input | 12 | Bin real part, signed |
| in_im | input | 12 | Bin imaginary part, signed |
| in_bad | input | 1 | Sample belongs to an unusable spectrum |
| cfg_we | input | 1 | Gain write strobe |
| cfg_ch | input | 1 | Channel index for the gain write |
| cfg_gain_re | input | 16 | Gain real part, 4096 = 1.0 |
| cfg_gain_im | input | 16 | Gain imaginary part |
| cfg_phase0 | input | 8 | Constant phase offset, 256 = full turn |
| cfg_phase_step | input | 8 | Per-channel phase increment |
| out_valid | output | 1 | Output beat valid |
| out_re | output | 8 | Quantized real part, signed |
| out_im | output | 8 | Quantized imaginary part, signed |
| out_last | output | 1 | Final beat of a heap |

## Verification
The bench sends odd inputs at half gain, so that every result falls exactly on a half. A design that truncated or rounded halves toward even would be off by one on most of these values. Full-scale inputs drive the results into the clamp, where an asymmetric clamp would emit −128. Large Nyquist values and a flag on a Nyquist sample show whether the extra bin leaks into the output or wrongly causes a heap to be dropped. A configuration change in the middle of a heap, followed by a heap sent back to back with no gap, exposes a design that applies updates mid-heap, and also one that loses or overwrites a bank when no idle cycles separate heaps.

// File: rtl/chan_correct_quant.sv
module chan_correct_quant #(
  parameter int NCH   = 2,
  parameter int NSPEC = 256,
  parameter int IW    = 12,
  parameter int GW    = 16,
  parameter int GF    = 12,
  parameter int PW    = 8,
  parameter int TW    = 16,
  parameter int OSH   = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_re,
  input  logic signed [IW-1:0] in_im,
  input  logic                 in_bad,
  input  logic                 cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic signed [GW-1:0] cfg_gain_re,
  input  logic signed [GW-1:0] cfg_gain_im,
  input  logic [PW-1:0]        cfg_phase0,
  input  logic [PW-1:0]        cfg_phase_step,
  output logic                 out_valid,
  output logic signed [7:0]    out_re,
  output logic signed [7:0]    out_im,
  output logic                 out_last
);
  localparam int KW    = $clog2(NCH + 1);
  localparam int CW    = $clog2(NCH);
  localparam int SW    = $clog2(NSPEC);
  localparam int DEPTH = NCH * NSPEC * 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int TF    = TW - 2;
  localparam int VW    = IW + TW + GW + 2;
  localparam real PI   = 3.141592653589793;

  function automatic logic signed [TW-1:0] trig_val(input int p, input bit sine);
    real a, v;
    int  r;
    a = 2.0 * PI * p / real'(2 ** PW);
    v = (sine ? $sin(a) : $cos(a)) * real'(2 ** TF);
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    return TW'(r);
  endfunction

  function automatic logic [7:0] quant(input logic signed [VW-1:0] v);
    logic [VW-1:0] m;
    m = v[VW-1] ? $unsigned(-v) : $unsigned(v);
    m = (m + (VW'(1) << (OSH - 1))) >> OSH;
    if (m > VW'(127)) m = VW'(127);
    return v[VW-1] ? 8'(8'd0 - m[7:0]) : m[7:0];
  endfunction

  logic signed [TW-1:0] cos_rom [2**PW];
  logic signed [TW-1:0] sin_rom [2**PW];
  for (genvar gp = 0; gp < 2**PW; gp++) begin : g_rom
    assign cos_rom[gp] = trig_val(gp, 1'b0);
    assign sin_rom[gp] = trig_val(gp, 1'b1);
  end

  logic [SW-1:0] s_c;
  logic [KW-1:0] k_c;
  logic          p_c, hbad, wb, rb;
  logic [1:0]    full;
  logic [AW-1:0] ra;
  logic [PW-1:0] p0_a, dp_a;
  logic signed [GW-1:0] gs_re [NCH];
  logic signed [GW-1:0] gs_im [NCH];
  logic signed [GW-1:0] ga_re [NCH];
  logic signed [GW-1:0] ga_im [NCH];
  logic [15:0] mem [2**(AW+1)];

  wire [CW-1:0] kch    = k_c[CW-1:0];
  wire          nyq    = (k_c == KW'(NCH));
  wire          hstart = (s_c == '0) && (k_c == '0) && !p_c;
  wire          hend   = (s_c == SW'(NSPEC - 1)) && nyq && p_c;
  wire          rd_end = (ra == AW'(DEPTH - 1));

  wire signed [GW-1:0] g_r = hstart ? gs_re[kch] : ga_re[kch];
  wire signed [GW-1:0] g_i = hstart ? gs_im[kch] : ga_im[kch];
  wire [PW-1:0] ph0 = hstart ? cfg_phase0 : p0_a;
  wire [PW-1:0] dph = hstart ? cfg_phase_step : dp_a;
  wire [PW-1:0] ph  = ph0 + PW'(k_c) * dph;

  wire signed [TW-1:0]    tc  = cos_rom[ph];
  wire signed [TW-1:0]    ts  = sin_rom[ph];
  wire signed [IW+TW:0]   a_r = in_re * tc - in_im * ts;
  wire signed [IW+TW:0]   a_i = in_re * ts + in_im * tc;
  wire signed [VW-1:0]    v_r = a_r * g_r - a_i * g_i;
  wire signed [VW-1:0]    v_i = a_r * g_i + a_i * g_r;
  wire [AW-1:0] waddr = AW'(kch) * AW'(2 * NSPEC) + AW'({s_c, p_c});

  always_ff @(posedge clk)
    if (in_valid && !nyq) mem[{wb, waddr}] <= {quant(v_r), quant(v_i)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_c <= '0; k_c <= '0; p_c <= 1'b0; hbad <= 1'b0;
      wb <= 1'b0; rb <= 1'b0; full <= '0; ra <= '0;
      p0_a <= '0; dp_a <= '0;
      out_valid <= 1'b0; out_last <= 1'b0; out_re <= '0; out_im <= '0;
      for (int i = 0; i < NCH; i++) begin
        gs_re[i] <= GW'(1 << GF); gs_im[i] <= '0;
        ga_re[i] <= GW'(1 << GF); ga_im[i] <= '0;
      end
    end else begin
      if (cfg_we) begin
        gs_re[cfg_ch] <= cfg_gain_re;
        gs_im[cfg_ch] <= cfg_gain_im;
      end
      if (in_valid) begin
        if (hstart) begin
          for (int i = 0; i < NCH; i++) begin
            ga_re[i] <= gs_re[i]; ga_im[i] <= gs_im[i];
          end
          p0_a <= cfg_phase0;
          dp_a <= cfg_phase_step;
        end
        if (!nyq) hbad <= hbad | in_bad;
        p_c <= !p_c;
        if (p_c) begin
          if (nyq) begin
            k_c <= '0;
            s_c <= (s_c == SW'(NSPEC - 1)) ? '0 : s_c + 1'b1;
          end else k_c <= k_c + 1'b1;
        end
        if (hend) begin
          hbad <= 1'b0;
          if (!hbad) begin
            full[wb] <= 1'b1;
            wb <= !wb;
          end
        end
      end
      out_valid <= full[rb];
      out_last  <= full[rb] && rd_end;
      if (full[rb]) begin
        {out_re, out_im} <= mem[{rb, ra}];
        ra <= rd_end ? '0 : ra + 1'b1;
        if (rd_end) begin
          full[rb] <= 1'b0;
          rb <= !rb;
        end
      end
    end
  end

  AST_BANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !nyq) |-> !full[wb]); // R9
  AST_KEEP_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hend && !hbad) |=> full[$past(wb)]); // R9
  AST_DROP_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hend && hbad) |=> !full[$past(wb)]); // R7
  AST_SYM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_re != -8'sd128) && (out_im != -8'sd128)); // R5
  AST_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid); // R6
endmodule

// File: tb/chan_correct_quant_tb.sv
module chan_correct_quant_tb;
  localparam int CLK_P = 10;
  localparam int NCH   = 2;
  localparam int NSPEC = 256;
  localparam int HSZ   = NCH * NSPEC * 2;
  localparam real PI   = 3.141592653589793;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_bad = 1'b0, cfg_we = 1'b0;
  logic signed [11:0] in_re = '0, in_im = '0;
  logic [0:0] cfg_ch = '0;
  logic signed [15:0] cfg_gain_re = '0, cfg_gain_im = '0;
  logic [7:0] cfg_phase0 = '0, cfg_phase_step = '0;
  logic out_valid, out_last;
  logic signed [7:0] out_re, out_im;

  always #(CLK_P/2) clk = ~clk;

  chan_correct_quant u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .in_bad(in_bad), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_gain_re(cfg_gain_re),
    .cfg_gain_im(cfg_gain_im), .cfg_phase0(cfg_phase0), .cfg_phase_step(cfg_phase_step),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_last(out_last));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int sh_gr[NCH], sh_gi[NCH];
  int hb_re[HSZ], hb_im[HSZ];
  int exp_re[$], exp_im[$], exp_last[$], got_re[$], got_im[$], got_last[$];
  string exp_tag[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint btrig(input int p, input bit sine);
    real a, v;
    a = 2.0 * PI * p / 256.0;
    v = (sine ? $sin(a) : $cos(a)) * 16384.0;
    return (v >= 0.0) ? longint'($rtoi(v + 0.5)) : -longint'($rtoi(-v + 0.5));
  endfunction

  function automatic int qnt(input longint v);
    longint m;
    m = (v < 0) ? -v : v;
    m = (m + (64'sd1 <<< 25)) / (64'sd1 <<< 26);
    if (m > 127) m = 127;
    return (v < 0) ? -int'(m) : int'(m);
  endfunction

  always @(negedge clk)
    if (out_valid) begin
      got_re.push_back(int'(out_re));
      got_im.push_back(int'(out_im));
      got_last.push_back(int'(out_last));
    end

  task automatic send_heap(input int kind, input int bad_s, input bit nyq_bad,
                           input bit mid_cfg, input bit gap, input string tag);
    int gr[NCH], gi[NCH];
    int p0, dp, re, im, idx;
    bit bad;
    bad = 1'b0;
    for (int i = 0; i < NCH; i++) begin gr[i] = sh_gr[i]; gi[i] = sh_gi[i]; end
    p0 = int'(cfg_phase0); dp = int'(cfg_phase_step);
    idx = 0;
    for (int s = 0; s < NSPEC; s++)
      for (int k = 0; k <= NCH; k++)
        for (int p = 0; p < 2; p++) begin
          @(negedge clk);
          case (kind)
            1: begin re = 2*$urandom_range(0, 9) - 9; im = 2*$urandom_range(0, 9) - 9; end
            2: begin re = $urandom_range(0, 4095) - 2048; im = $urandom_range(0, 4095) - 2048; end
            default: begin re = $urandom_range(0, 200) - 100; im = $urandom_range(0, 200) - 100; end
          endcase
          if (k == NCH) begin re = 2047; im = -2048; end
          in_valid = 1'b1; in_re = 12'(re); in_im = 12'(im);
          in_bad = (s == bad_s && k == 0 && p == 1) || (nyq_bad && k == NCH && s == 3);
          if (s == bad_s) bad = 1'b1;
          cfg_we = 1'b0;
          if (mid_cfg && idx == 7) begin
            cfg_we = 1'b1; cfg_ch = 1'b1;
            cfg_gain_re = 16'($urandom_range(0, 8191) - 4096);
            cfg_gain_im = 16'($urandom_range(0, 8191) - 4096);
            sh_gr[1] = int'(cfg_gain_re); sh_gi[1] = int'(cfg_gain_im);
            cfg_phase0 = 8'($urandom); cfg_phase_step = 8'($urandom);
          end
          idx++;
          if (k < NCH) begin
            longint c, sn, a, b, vr, vi;
            int ph;
            ph = (p0 + k * dp) % 256;
            c = btrig(ph, 1'b0); sn = btrig(ph, 1'b1);
            a = re * c - im * sn; b = re * sn + im * c;
            vr = a * gr[k] - b * gi[k]; vi = a * gi[k] + b * gr[k];
            hb_re[(k*NSPEC + s)*2 + p] = qnt(vr);
            hb_im[(k*NSPEC + s)*2 + p] = qnt(vi);
          end
        end
    if (!bad)
      for (int i = 0; i < HSZ; i++) begin
        exp_re.push_back(hb_re[i]); exp_im.push_back(hb_im[i]);
        exp_last.push_back(i == HSZ - 1); exp_tag.push_back(tag);
      end
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0; in_bad = 1'b0; cfg_we = 1'b0;
      chk(out_valid == 1'b0, "R9 early", int'(out_valid), 0);
      @(negedge clk);
      chk(out_valid == !bad, bad ? "R7 drop" : "R9 start", int'(out_valid), int'(!bad));
      repeat (HSZ + 4) @(negedge clk);
    end
  endtask

  task automatic set_gain(input int k, input int gr, input int gi);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 1'(k); cfg_gain_re = 16'(gr); cfg_gain_im = 16'(gi);
    sh_gr[k] = gr; sh_gi[k] = gi;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCH; i++) begin sh_gr[i] = 4096; sh_gi[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset", int'(out_valid), 0);
    send_heap(0, -1, 1'b0, 1'b0, 1'b1, "R10");
    for (int k = 0; k < NCH; k++) set_gain(k, 2048, 0);
    send_heap(1, -1, 1'b0, 1'b0, 1'b1, "R4");
    for (int k = 0; k < NCH; k++) set_gain(k, 4096, 0);
    send_heap(2, -1, 1'b0, 1'b0, 1'b1, "R5");
    cfg_phase0 = 8'd37; cfg_phase_step = 8'd90;
    send_heap(0, -1, 1'b0, 1'b0, 1'b1, "R2");
    cfg_phase0 = 8'd0; cfg_phase_step = 8'd0;
    set_gain(0, 3000, -2500); set_gain(1, -1234, 5000);
    send_heap(0, -1, 1'b0, 1'b0, 1'b1, "R3");
    cfg_phase0 = 8'd200; cfg_phase_step = 8'd13;
    send_heap(3, -1, 1'b0, 1'b0, 1'b1, "R2");
    send_heap(0, 100, 1'b0, 1'b0, 1'b1, "R7");
    send_heap(0, -1, 1'b0, 1'b0, 1'b1, "R7");
    send_heap(0, -1, 1'b1, 1'b0, 1'b1, "R1");
    send_heap(0, -1, 1'b0, 1'b1, 1'b0, "R8");
    send_heap(0, -1, 1'b0, 1'b0, 1'b1, "R8");
    repeat (HSZ + 8) @(negedge clk);
    chk(got_re.size() == exp_re.size(), "R6 count", got_re.size(), exp_re.size());
    for (int i = 0; i < exp_re.size() && i < got_re.size(); i++) begin
      chk(got_re[i] == exp_re[i] && got_im[i] == exp_im[i], exp_tag[i],
          got_re[i] * 1000 + got_im[i], exp_re[i] * 1000 + exp_im[i]);
      chk(got_last[i] == exp_last[i], "R6 last", got_last[i], exp_last[i]);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        if (!done) chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule